// File: doc/BRIEF.md
# Trap Entry and Privilege Controller

This block decides when the instruction stream is diverted to a handler and keeps the single bit that says whether the core runs in supervisor or user mode. Six request sources feed it: a programmable countdown timer, four level-sensitive hardware lines and a system-call request. The system-call request is raised when the issuing instruction is a system call. When an instruction is about to issue and a request is pending, the block does not let that instruction proceed. It records where execution must resume, looks up the handler target in a small table held inside the block, forces supervisor mode, and sends a redirect to the fetch stage.

A return instruction in the handler sends execution back to the saved resume address and restores the mode that was active before the trap. An explicit instruction can drop from supervisor to user mode. No instruction can climb back up: a trap is the only way in. The operating system arms the timer before it releases a user process, and the timer expiring is how control comes back. The handler table and the timer can be programmed only in supervisor mode.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, supervisor is 1, in_handler, redirect and priv_fault are 0, the timer is disarmed, and handler entry k holds VEC_BASE + k*VEC_STRIDE (defaults 0x100 and 0x40).
- R2: At a clock edge with issue_valid high, in_handler low and at least one source pending, a trap is taken. In the next cycle redirect is 1 for one cycle, redirect_pc is the handler entry of the winning source, cause is its number, and supervisor and in_handler are 1. Pending sources with issue_valid low cause no trap.
- R3: Source numbers are: 0 for the timer, k for irq_lines[k-1] (k = 1..NUM_HW), and NUM_HW+1 for a system call (syscall_op together with issue_valid). The lowest pending number wins.
- R4: The saved resume address is issue_pc when the winner is the timer or a hardware line, and issue_pc + INSN_BYTES (default 4) when the winner is the system call.
- R5: While in_handler is 1, no new trap is taken. Requests that stay pending are taken at the first issuing instruction after the return.
- R6: ret_op with issue_valid while in_handler is 1 produces, in the next cycle, redirect = 1 with redirect_pc equal to the saved resume address, supervisor restored to its value before the trap, and in_handler = 0. ret_op outside a handler has no effect.
- R7: drop_priv with issue_valid clears supervisor when not in a handler. supervisor goes from 0 to 1 only by taking a trap.
- R8: cfg_we while supervisor is 1 writes cfg_wdata to handler entry cfg_idx (cfg_sel = 0) or to the timer (cfg_sel = 1). cfg_we while supervisor is 0 changes nothing and sets priv_fault for exactly the next cycle.
- R9: A timer write of N > 0 at edge E arms it. Source 0 becomes pending after edge E+N, so an instruction issuing at E+N+1 is trapped. A write of 0 disarms the timer, and taking source 0 clears its pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | NUM_HW | Level-sensitive hardware request lines |
| issue_valid | input | 1 | An instruction is about to issue this cycle |
| issue_pc | input | PC_W | Address of the issuing instruction |
| syscall_op | input | 1 | The issuing instruction is a system call |
| ret_op | input | 1 | The issuing instruction is a handler return |
| drop_priv | input | 1 | The issuing instruction leaves supervisor mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 handler table, 1 timer |
| cfg_idx | input | IDX_W | Handler table entry to write |
| cfg_wdata | input | PC_W | Handler address or timer count |
| redirect | output | 1 | Fetch must go to redirect_pc |
| redirect_pc | output | PC_W | Handler target or resume address |
| cause | output | IDX_W | Number of the source last taken |
| supervisor | output | 1 | Current mode bit, 1 for supervisor |
| in_handler | output | 1 | A trap is being serviced and requests are masked |
| priv_fault | output | 1 | A configuration write was refused in user mode |

## Verification
The hardest case to reach from the ports is a timer expiry that lands on the same edge as an issuing system call. Only that pairing shows that the timer outranks the call and that the resume address then points back at the call rather than past it. The stimulus arms the timer with a known count in supervisor mode and drops to user mode on the next edge. It then keeps instructions issuing and counts edges, so that a system call is presented exactly on the edge where source 0 first becomes pending. The cycles before that edge are also checked, to confirm that no trap fires early.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic {
        CFG_VECTOR = 1'b0,
        CFG_TIMER  = 1'b1
    } cfg_target_e;

    // width of an index able to name n sources (at least one bit)
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // handler address that entry idx holds after reset
    function automatic longint unsigned reset_vector(input longint unsigned base,
                                                     input longint unsigned stride,
                                                     input int idx);
        return base + stride * longint'(idx);
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    // scan from the top down so the lowest requesting number is left in idx
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        grant = valid ? (N'(1) << idx) : '0;
    end

    // R3: a grant never passes over a lower pending source
    p_lowest_wins_r3: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((req & (grant - N'(1))) == '0) && ((req & grant) != '0));

    p_single_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
    parameter int          N      = 6,
    parameter int          IDX_W  = 3,
    parameter int          PC_W   = 32,
    parameter logic [63:0] BASE   = 64'h100,
    parameter logic [63:0] STRIDE = 64'h40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [PC_W-1:0]  wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [PC_W-1:0]  rdata
);
    import trap_pkg::*;

    logic [PC_W-1:0] entry [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                entry[i] <= PC_W'(reset_vector(BASE, STRIDE, i));
            end else if (we && (widx == IDX_W'(i))) begin
                entry[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (ridx == IDX_W'(i)) rdata = entry[i];
        end
    end

    // R8: an entry read back unchanged unless a write addressed it
    p_entry_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (!we || widx != ridx) |=> (ridx != $past(ridx)) || $stable(rdata));

endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             ack,
    output logic             pending
);

    logic [TMR_W-1:0] remain;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain  <= '0;
            armed   <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (ack) pending <= 1'b0;
            if (load) begin
                remain  <= load_val;
                armed   <= (load_val != '0);
                pending <= 1'b0;
            end else if (armed) begin
                if (remain == TMR_W'(1)) begin
                    remain  <= '0;
                    armed   <= 1'b0;
                    pending <= 1'b1;
                end else begin
                    remain <= remain - TMR_W'(1);
                end
            end
        end
    end

    // R9: the last count of an armed timer raises the request
    p_expiry_raises_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && remain == TMR_W'(1) && !load) |=> pending);

    // R9: a zero load leaves nothing pending
    p_zero_disarms_r9: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> !pending && !armed);

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
    parameter int          NUM_HW     = 4,
    parameter int          PC_W       = 32,
    parameter int          TMR_W      = 16,
    parameter logic [63:0] VEC_BASE   = 64'h100,
    parameter logic [63:0] VEC_STRIDE = 64'h40,
    parameter int          INSN_BYTES = 4,
    parameter int          NSRC       = NUM_HW + 2,
    parameter int          IDX_W      = trap_pkg::idx_width(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_HW-1:0] irq_lines,
    input  logic              issue_valid,
    input  logic [PC_W-1:0]   issue_pc,
    input  logic              syscall_op,
    input  logic              ret_op,
    input  logic              drop_priv,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [PC_W-1:0]   cfg_wdata,
    output logic              redirect,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [IDX_W-1:0]  cause,
    output logic              supervisor,
    output logic              in_handler,
    output logic              priv_fault
);
    import trap_pkg::*;

    localparam int TIMER_SRC = 0;
    localparam int SYS_SRC   = NUM_HW + 1;

    cfg_target_e       cfg_target;
    logic [NSRC-1:0]   req_vec;
    logic [NSRC-1:0]   grant;
    logic              arb_valid;
    logic [IDX_W-1:0]  arb_idx;
    logic [PC_W-1:0]   handler_pc;
    logic              tmr_pending;
    logic              take, do_ret, do_drop, cfg_ok;
    logic [PC_W-1:0]   resume_q;
    logic              prior_mode_q;

    assign cfg_target = cfg_target_e'(cfg_sel);
    assign req_vec    = {syscall_op & issue_valid, irq_lines, tmr_pending};

    trap_arbiter #(.N(NSRC), .IDX_W(IDX_W)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req_vec),
        .valid (arb_valid),
        .idx   (arb_idx),
        .grant (grant)
    );

    trap_vec_table #(
        .N(NSRC), .IDX_W(IDX_W), .PC_W(PC_W), .BASE(VEC_BASE), .STRIDE(VEC_STRIDE)
    ) u_vec (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_ok && cfg_target == CFG_VECTOR),
        .widx  (cfg_idx),
        .wdata (cfg_wdata),
        .ridx  (arb_idx),
        .rdata (handler_pc)
    );

    trap_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_ok && cfg_target == CFG_TIMER),
        .load_val (cfg_wdata[TMR_W-1:0]),
        .ack      (take && grant[TIMER_SRC]),
        .pending  (tmr_pending)
    );

    always_comb begin
        take    = issue_valid && !in_handler && arb_valid;
        do_ret  = issue_valid && ret_op && in_handler;
        do_drop = issue_valid && drop_priv && supervisor && !in_handler && !take;
        cfg_ok  = cfg_we && supervisor;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            supervisor   <= 1'b1;
            prior_mode_q <= 1'b1;
            in_handler   <= 1'b0;
            redirect     <= 1'b0;
            redirect_pc  <= '0;
            cause        <= '0;
            resume_q     <= '0;
            priv_fault   <= 1'b0;
        end else begin
            redirect   <= take || do_ret;
            priv_fault <= cfg_we && !supervisor;
            if (take) begin
                resume_q     <= grant[SYS_SRC] ? issue_pc + PC_W'(INSN_BYTES) : issue_pc;
                prior_mode_q <= supervisor;
                supervisor   <= 1'b1;
                in_handler   <= 1'b1;
                redirect_pc  <= handler_pc;
                cause        <= arb_idx;
            end else if (do_ret) begin
                redirect_pc <= resume_q;
                supervisor  <= prior_mode_q;
                in_handler  <= 1'b0;
            end else if (do_drop) begin
                supervisor <= 1'b0;
            end
        end
    end

    // R7: the mode bit climbs only through a trap
    p_sup_only_by_trap_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(supervisor) |-> $past(take));

    p_drop_to_user_r7: assert property (@(posedge clk) disable iff (rst)
        do_drop |=> !supervisor);

    // R2 / R5: a taken trap enters supervisor and masks further requests
    p_take_enters_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> redirect && supervisor && in_handler);

    p_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (in_handler && !do_ret) |=> in_handler && !redirect);

    // R6: return leaves the handler
    p_ret_leaves_r6: assert property (@(posedge clk) disable iff (rst)
        do_ret |=> redirect && !in_handler);

    // R8: refused configuration write flags a fault
    p_user_cfg_fault_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !supervisor) |=> priv_fault);

endmodule

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 3;
    localparam int NV         = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic [3:0]        irq_lines;
    logic              issue_valid;
    logic [31:0]       issue_pc;
    logic              syscall_op, ret_op, drop_priv;
    logic              cfg_we, cfg_sel;
    logic [IDX_W-1:0]  cfg_idx;
    logic [31:0]       cfg_wdata;
    logic              redirect;
    logic [31:0]       redirect_pc;
    logic [IDX_W-1:0]  cause;
    logic              supervisor, in_handler, priv_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // priority table: hardware lines, system call, expected winner
    localparam logic [3:0] T_IRQ   [NV] = '{4'b0001, 4'b1010, 4'b1000, 4'b0000, 4'b1100, 4'b0110};
    localparam logic       T_SYS   [NV] = '{1'b0,    1'b0,    1'b1,    1'b1,    1'b0,    1'b1};
    localparam int         T_CAUSE [NV] = '{1,       2,       4,       5,       3,       2};

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_ctrl dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .issue_valid(issue_valid),
        .issue_pc(issue_pc), .syscall_op(syscall_op), .ret_op(ret_op),
        .drop_priv(drop_priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .redirect(redirect), .redirect_pc(redirect_pc),
        .cause(cause), .supervisor(supervisor), .in_handler(in_handler),
        .priv_fault(priv_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        irq_lines = '0; issue_valid = 0; issue_pc = '0; syscall_op = 0;
        ret_op = 0; drop_priv = 0; cfg_we = 0; cfg_sel = 0; cfg_idx = '0; cfg_wdata = '0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic issue_ret(input logic [31:0] exp_pc, input logic exp_sup, input string req);
        issue_valid = 1; ret_op = 1; issue_pc = 32'h9990;
        tick();
        issue_valid = 0; ret_op = 0;
        chk({req, " ret redirect"}, 32'(redirect), 32'd1);
        chk({req, " ret pc"}, redirect_pc, exp_pc);
        chk({req, " ret mode"}, 32'(supervisor), 32'(exp_sup));
        chk({req, " ret leaves handler"}, 32'(in_handler), 32'd0);
        tick();
    endtask

    task automatic drop_mode();
        issue_valid = 1; drop_priv = 1; issue_pc = 32'h500;
        tick();
        issue_valid = 0; drop_priv = 0;
    endtask

    initial begin
        logic [31:0] pc;
        logic        prior;
        do_reset();

        // R1: reset state
        chk("R1 supervisor", 32'(supervisor), 32'd1);
        chk("R1 in_handler", 32'(in_handler), 32'd0);
        chk("R1 redirect", 32'(redirect), 32'd0);
        chk("R1 priv_fault", 32'(priv_fault), 32'd0);

        // R2 R3 R4 R6 R7: table walk over request patterns
        for (int i = 0; i < NV; i++) begin
            pc = 32'h1000 + 32'(i) * 32'h10;
            if (i % 2 == 1) begin
                drop_mode();
                chk("R7 drop to user", 32'(supervisor), 32'd0);
            end
            prior = supervisor;
            irq_lines = T_IRQ[i]; syscall_op = T_SYS[i]; issue_valid = 1; issue_pc = pc;
            tick();
            idle();
            chk("R2 redirect", 32'(redirect), 32'd1);
            chk("R3 cause", 32'(cause), 32'(T_CAUSE[i]));
            chk("R1 R2 handler pc", redirect_pc, 32'h100 + 32'h40 * 32'(T_CAUSE[i]));
            chk("R2 supervisor", 32'(supervisor), 32'd1);
            chk("R2 in_handler", 32'(in_handler), 32'd1);
            tick();
            chk("R2 single pulse", 32'(redirect), 32'd0);
            issue_ret((T_CAUSE[i] == 5) ? pc + 32'd4 : pc, prior, "R4 R6");
        end

        // R2: requests without an issuing instruction wait
        do_reset();
        irq_lines = 4'b0100;
        tick(); tick();
        chk("R2 no issue no trap", 32'(redirect), 32'd0);
        chk("R2 no issue no handler", 32'(in_handler), 32'd0);

        // R6: return outside a handler is ignored
        irq_lines = '0; issue_valid = 1; ret_op = 1; issue_pc = 32'h40;
        tick();
        idle();
        chk("R6 stray ret", 32'(redirect), 32'd0);
        chk("R6 stray ret mode", 32'(supervisor), 32'd1);

        // R5: masking while in the handler, request still held after return
        irq_lines = 4'b0001; issue_valid = 1; issue_pc = 32'h2000;
        tick();
        chk("R5 first entry", 32'(cause), 32'd1);
        irq_lines = 4'b0101; issue_pc = 32'h2004;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5 masked", 32'(redirect), 32'd0);
        end
        issue_valid = 0;
        issue_ret(32'h2000, 1'b1, "R5");
        issue_valid = 1; issue_pc = 32'h2100;
        tick();
        chk("R5 held request taken", 32'(redirect), 32'd1);
        chk("R5 held request cause", 32'(cause), 32'd1);
        idle();
        tick();
        issue_ret(32'h2100, 1'b1, "R5");

        // R8: supervisor write reprograms an entry
        cfg_we = 1; cfg_sel = 0; cfg_idx = 3'd2; cfg_wdata = 32'h2222_0000;
        tick();
        idle();
        chk("R8 no fault in supervisor", 32'(priv_fault), 32'd0);
        drop_mode();
        // R8: user write is refused and flagged
        cfg_we = 1; cfg_sel = 0; cfg_idx = 3'd2; cfg_wdata = 32'hDEAD_0000;
        tick();
        idle();
        chk("R8 fault pulse", 32'(priv_fault), 32'd1);
        tick();
        chk("R8 fault one cycle", 32'(priv_fault), 32'd0);
        irq_lines = 4'b0010; issue_valid = 1; issue_pc = 32'h3000;
        tick();
        idle();
        chk("R8 entry kept", redirect_pc, 32'h2222_0000);
        tick();
        issue_ret(32'h3000, 1'b0, "R8");

        // R9: timer expiry coinciding with a system call
        do_reset();
        cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'd5;
        tick();                                   // edge E0
        idle();
        drop_mode();                              // edge E1
        chk("R7 user before expiry", 32'(supervisor), 32'd0);
        for (int e = 2; e <= 5; e++) begin
            issue_valid = 1; issue_pc = 32'h4000 + 32'(e);
            tick();
            chk("R9 no early expiry", 32'(redirect), 32'd0);
        end
        issue_valid = 1; syscall_op = 1; issue_pc = 32'h5000;
        tick();                                   // edge E6
        idle();
        chk("R9 expiry taken", 32'(redirect), 32'd1);
        chk("R3 R9 timer beats syscall", 32'(cause), 32'd0);
        chk("R9 handler pc", redirect_pc, 32'h100);
        chk("R7 trap enters supervisor", 32'(supervisor), 32'd1);
        tick();
        issue_ret(32'h5000, 1'b0, "R4 R9");

        // R8 R9: timer write from user mode does not arm it
        cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'd2;
        tick();
        idle();
        chk("R8 timer write refused", 32'(priv_fault), 32'd1);
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                issue_valid = 1; issue_pc = 32'h6000;
                tick();
                if (redirect) seen++;
            end
            idle();
            chk("R8 R9 timer stays idle", 32'(seen), 32'd0);
        end

        // R9: zero write disarms
        do_reset();
        cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'd3;
        tick();
        cfg_wdata = 32'd0;
        tick();
        idle();
        begin
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                issue_valid = 1; issue_pc = 32'h7000;
                tick();
                if (redirect) seen++;
            end
            idle();
            chk("R9 zero disarms", 32'(seen), 32'd0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule